// File: doc/BRIEF.md
# Squashable Instruction Buffer with Register Credits

This block sits between instruction fetch and dispatch. Fetch pushes records into the tail of a circular queue, and dispatch pops them from the head. Each record carries a sequence number and a count of destination registers. The block also holds a pool of free physical-register credits. An accepted push charges its destination count against that pool. Registers that the back end releases come back through an external free port, and the pool is clamped at the physical register total.

A squash request carries a limit sequence number. The block then walks backward from the tail, removing one entry per cycle while the youngest remaining entry is newer than the limit. It returns each removed entry's destination count to the pool. While the walk runs, a busy flag is raised and pushes and pops are refused. Two free-running counters record pipeline behaviour: one sums the occupancy every cycle, and the other counts the cycles in which the queue is full.

Top module: `ibuf_squash_top`

## Requirements
- R1: After reset the occupancy is 0, `empty` is 1, `full`, `busy` and `pop_valid` are 0, `free_regs` equals NUM_PREGS, and both statistics counters are 0.
- R2: Entries leave in push order. A pop accepted at a clock edge presents `pop_valid`=1 together with that entry's sequence number and destination count after the same edge.
- R3: A pop on an empty queue returns nothing: `pop_valid` stays 0 and the occupancy is unchanged.
- R4: A push is refused when the occupancy equals DEPTH, and `full` is 1 in that state. An accepted push together with an accepted pop leaves the occupancy unchanged.
- R5: An accepted push lowers `free_regs` by its destination count. A push whose destination count exceeds `free_regs` is refused.
- R6: `rename_blocked` is 1 exactly while `free_regs` is 0. An external free that makes the pool positive clears it.
- R7: An external free adds `free_num` to the pool. The pool, including squash refunds, never exceeds NUM_PREGS and saturates there.
- R8: After `squash_req` with limit S, `busy` rises at the next edge. At each following edge, one tail entry is removed if its sequence number is greater than S (unsigned compare). `busy` falls at the first edge where the tail entry is not newer than S or the queue is empty.
- R9: Each entry removed by a squash adds its destination count back to `free_regs`.
- R10: Pushes and pops are refused in the cycle `squash_req` is high and in every cycle `busy` is high.
- R11: At every edge, `occ_sum` grows by the occupancy held before that edge, and `full_cycles` grows by one when that occupancy equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | 1 | Push request from fetch |
| push_seq | input | SEQ_W | Sequence number of the pushed record |
| push_ndest | input | ND_W | Destination-register count of the pushed record |
| pop_en | input | 1 | Pop request from dispatch |
| squash_req | input | 1 | Start a squash walk |
| squash_seq | input | SEQ_W | Squash limit; entries newer than this are removed |
| free_en | input | 1 | External register release strobe |
| free_num | input | $clog2(NUM_PREGS+1) | Number of registers released |
| count | output | $clog2(DEPTH+1) | Current occupancy |
| full | output | 1 | Occupancy equals DEPTH |
| empty | output | 1 | Occupancy is zero |
| busy | output | 1 | Squash walk in progress |
| pop_valid | output | 1 | Popped record is presented |
| pop_seq | output | SEQ_W | Sequence number of the popped record |
| pop_ndest | output | ND_W | Destination count of the popped record |
| free_regs | output | $clog2(NUM_PREGS+1) | Free register credits |
| rename_blocked | output | 1 | No credits left |
| occ_sum | output | STAT_W | Cumulative occupancy |
| full_cycles | output | STAT_W | Cycles spent full |

## Verification
The bench builds the block with DEPTH=4, NUM_PREGS=8, ND_W=2 and SEQ_W=8. With these values a few pushes fill the queue, a few more exhaust the credit pool, and an over-generous external free hits the saturation ceiling. A squash that reaches past the oldest entry can also drain the queue in a handful of cycles. These sizes let the same short run cover the refused-push paths for both a full queue and missing credits, the stop-on-empty end of the squash walk, and clamping on refunds as well as on external frees.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  typedef enum logic {SQ_IDLE = 1'b0, SQ_WALK = 1'b1} sq_state_t;
endpackage

// File: rtl/ibuf_ring.sv
module ibuf_ring #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int ND_W  = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEQ_W-1:0] wr_seq,
  input  logic [ND_W-1:0]  wr_nd,
  input  logic             rd_en,
  input  logic             drop_tail,
  output logic [CW-1:0]    count,
  output logic             rd_valid,
  output logic [SEQ_W-1:0] rd_seq,
  output logic [ND_W-1:0]  rd_nd,
  output logic [SEQ_W-1:0] tail_seq,
  output logic [ND_W-1:0]  tail_nd
);
  logic [SEQ_W-1:0] seq_mem [DEPTH];
  logic [ND_W-1:0]  nd_mem  [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr, tail_idx;

  assign tail_idx = wr_ptr - AW'(1);
  assign tail_seq = seq_mem[tail_idx];
  assign tail_nd  = nd_mem[tail_idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      seq_mem[wr_ptr] <= wr_seq;
      nd_mem[wr_ptr]  <= wr_nd;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_seq <= seq_mem[rd_ptr];
      rd_nd  <= nd_mem[rd_ptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      if (wr_en)          wr_ptr <= wr_ptr + AW'(1);
      else if (drop_tail) wr_ptr <= wr_ptr - AW'(1);
      count <= count + CW'(wr_en) - CW'(rd_en) - CW'(drop_tail);
    end
  end

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R4
  pair_keep_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_en && !drop_tail |=> count == $past(count));
endmodule

// File: rtl/ibuf_credits.sv
module ibuf_credits #(
  parameter int NUM_PREGS = 32,
  parameter int ND_W      = 2,
  localparam int FW = $clog2(NUM_PREGS + 1),
  localparam int EW = FW + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            charge_en,
  input  logic [ND_W-1:0] charge_n,
  input  logic            refund_en,
  input  logic [ND_W-1:0] refund_n,
  input  logic            ext_en,
  input  logic [FW-1:0]   ext_n,
  output logic [FW-1:0]   free_cnt,
  output logic            blocked
);
  logic [EW-1:0] sum;
  logic [FW-1:0] nxt;

  always_comb begin
    sum = {2'b00, free_cnt};
    if (refund_en) sum = sum + EW'(refund_n);
    if (ext_en)    sum = sum + EW'(ext_n);
    if (charge_en) sum = sum - EW'(charge_n);
    if (sum > EW'(NUM_PREGS)) nxt = FW'(NUM_PREGS);
    else                      nxt = sum[FW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_cnt <= FW'(NUM_PREGS);
      blocked  <= 1'b0;
    end else begin
      free_cnt <= nxt;
      blocked  <= (nxt == '0);
    end
  end

  // R7
  free_cap_chk: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= FW'(NUM_PREGS));

  // R5
  charge_chk: assert property (@(posedge clk) disable iff (rst)
    charge_en && !refund_en && !ext_en |=>
      free_cnt == FW'($past(free_cnt) - FW'($past(charge_n))));
endmodule

// File: rtl/ibuf_stats.sv
module ibuf_stats #(
  parameter int DEPTH  = 8,
  parameter int STAT_W = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     count,
  output logic [STAT_W-1:0] occ_sum,
  output logic [STAT_W-1:0] full_cycles
);
  always_ff @(posedge clk) begin
    if (rst) begin
      occ_sum     <= '0;
      full_cycles <= '0;
    end else begin
      occ_sum <= occ_sum + STAT_W'(count);
      if (count == CW'(DEPTH)) full_cycles <= full_cycles + STAT_W'(1);
    end
  end

  // R11
  occ_mono_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> occ_sum >= $past(occ_sum));
endmodule

// File: rtl/ibuf_squash_top.sv
module ibuf_squash_top
  import ibuf_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 8,
  parameter int ND_W      = 2,
  parameter int NUM_PREGS = 32,
  parameter int STAT_W    = 32,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int FW = $clog2(NUM_PREGS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [SEQ_W-1:0]  push_seq,
  input  logic [ND_W-1:0]   push_ndest,
  input  logic              pop_en,
  input  logic              squash_req,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              free_en,
  input  logic [FW-1:0]     free_num,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic              busy,
  output logic              pop_valid,
  output logic [SEQ_W-1:0]  pop_seq,
  output logic [ND_W-1:0]   pop_ndest,
  output logic [FW-1:0]     free_regs,
  output logic              rename_blocked,
  output logic [STAT_W-1:0] occ_sum,
  output logic [STAT_W-1:0] full_cycles
);
  sq_state_t        sq_state;
  logic [SEQ_W-1:0] sq_limit;
  logic             hold, push_ok, pop_ok, drop;
  logic [SEQ_W-1:0] tail_seq;
  logic [ND_W-1:0]  tail_nd;

  assign busy  = (sq_state == SQ_WALK);
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign hold  = squash_req || busy;

  assign push_ok = push_en && !hold && !full && (FW'(push_ndest) <= free_regs);
  assign pop_ok  = pop_en && !hold && !empty;
  assign drop    = busy && !empty && (tail_seq > sq_limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_state <= SQ_IDLE;
      sq_limit <= '0;
    end else if (squash_req) begin
      sq_state <= SQ_WALK;
      sq_limit <= squash_seq;
    end else if (busy && !drop) begin
      sq_state <= SQ_IDLE;
    end
  end

  ibuf_ring #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ND_W(ND_W)) u_ring (
    .clk(clk), .rst(rst),
    .wr_en(push_ok), .wr_seq(push_seq), .wr_nd(push_ndest),
    .rd_en(pop_ok), .drop_tail(drop),
    .count(count), .rd_valid(pop_valid), .rd_seq(pop_seq), .rd_nd(pop_ndest),
    .tail_seq(tail_seq), .tail_nd(tail_nd)
  );

  ibuf_credits #(.NUM_PREGS(NUM_PREGS), .ND_W(ND_W)) u_credits (
    .clk(clk), .rst(rst),
    .charge_en(push_ok), .charge_n(push_ndest),
    .refund_en(drop), .refund_n(tail_nd),
    .ext_en(free_en), .ext_n(free_num),
    .free_cnt(free_regs), .blocked(rename_blocked)
  );

  ibuf_stats #(.DEPTH(DEPTH), .STAT_W(STAT_W)) u_stats (
    .clk(clk), .rst(rst), .count(count),
    .occ_sum(occ_sum), .full_cycles(full_cycles)
  );

  // R8
  squash_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> count <= $past(count));

  // R10
  hold_pop_chk: assert property (@(posedge clk) disable iff (rst)
    hold && pop_en |=> !pop_valid);
endmodule

// File: tb/ibuf_squash_top_tb.sv
`timescale 1ns/1ps
module ibuf_squash_top_tb;
  localparam int DEPTH = 4, SEQ_W = 8, ND_W = 2, NP = 8, STAT_W = 32;
  localparam int CW = $clog2(DEPTH + 1), FW = $clog2(NP + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic push_en = 0, pop_en = 0, squash_req = 0, free_en = 0;
  logic [SEQ_W-1:0] push_seq = '0, squash_seq = '0;
  logic [ND_W-1:0]  push_ndest = '0;
  logic [FW-1:0]    free_num = '0;
  logic [CW-1:0]    count;
  logic full, empty, busy, pop_valid, rename_blocked;
  logic [SEQ_W-1:0] pop_seq;
  logic [ND_W-1:0]  pop_ndest;
  logic [FW-1:0]    free_regs;
  logic [STAT_W-1:0] occ_sum, full_cycles;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ibuf_squash_top #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ND_W(ND_W),
                    .NUM_PREGS(NP), .STAT_W(STAT_W)) u_dut (
    .clk(clk), .rst(rst), .push_en(push_en), .push_seq(push_seq),
    .push_ndest(push_ndest), .pop_en(pop_en), .squash_req(squash_req),
    .squash_seq(squash_seq), .free_en(free_en), .free_num(free_num),
    .count(count), .full(full), .empty(empty), .busy(busy),
    .pop_valid(pop_valid), .pop_seq(pop_seq), .pop_ndest(pop_ndest),
    .free_regs(free_regs), .rename_blocked(rename_blocked),
    .occ_sum(occ_sum), .full_cycles(full_cycles)
  );

  // push, seq, nd, pop, exp count, exp free, exp pop_valid, exp pop seq
  localparam logic [27:0] VEC [12] = '{
    {1'b1, 8'd1, 2'd2, 1'b0, 3'd1, 4'd6, 1'b0, 8'd0},
    {1'b1, 8'd2, 2'd1, 1'b0, 3'd2, 4'd5, 1'b0, 8'd0},
    {1'b1, 8'd3, 2'd3, 1'b0, 3'd3, 4'd2, 1'b0, 8'd0},
    {1'b1, 8'd4, 2'd0, 1'b0, 3'd4, 4'd2, 1'b0, 8'd0},
    {1'b1, 8'd5, 2'd1, 1'b0, 3'd4, 4'd2, 1'b0, 8'd0},
    {1'b0, 8'd0, 2'd0, 1'b1, 3'd3, 4'd2, 1'b1, 8'd1},
    {1'b1, 8'd5, 2'd1, 1'b1, 3'd3, 4'd1, 1'b1, 8'd2},
    {1'b1, 8'd6, 2'd2, 1'b0, 3'd3, 4'd1, 1'b0, 8'd0},
    {1'b0, 8'd0, 2'd0, 1'b1, 3'd2, 4'd1, 1'b1, 8'd3},
    {1'b0, 8'd0, 2'd0, 1'b1, 3'd1, 4'd1, 1'b1, 8'd4},
    {1'b0, 8'd0, 2'd0, 1'b1, 3'd0, 4'd1, 1'b1, 8'd5},
    {1'b0, 8'd0, 2'd0, 1'b1, 3'd0, 4'd1, 1'b0, 8'd0}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push1(input int s, input int n);
    push_en = 1'b1; push_seq = SEQ_W'(s); push_ndest = ND_W'(n);
    @(negedge clk);
    push_en = 1'b0;
  endtask

  task automatic give(input int n);
    free_en = 1'b1; free_num = FW'(n);
    @(negedge clk);
    free_en = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 count", int'(count), 0);
    check("R1 empty", int'(empty), 1);
    check("R1 full", int'(full), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 pop_valid", int'(pop_valid), 0);
    check("R1 free", int'(free_regs), NP);
    check("R1 occ_sum", int'(occ_sum), 0);
    check("R1 full_cycles", int'(full_cycles), 0);

    // R11 statistics: counts 0,1,2,3,4,4,4 before seven edges
    for (int i = 1; i <= 4; i++) push1(i, 0);
    repeat (3) @(negedge clk);
    check("R11 occ_sum", int'(occ_sum), 18);
    check("R11 full_cycles", int'(full_cycles), 3);
    check("R4 full flag", int'(full), 1);

    // Vector table: R2 order, R3 empty pop, R4 full refusal, R5 credits
    do_reset();
    for (int v = 0; v < 12; v++) begin
      push_en = VEC[v][27]; push_seq = VEC[v][26:19];
      push_ndest = VEC[v][18:17]; pop_en = VEC[v][16];
      @(negedge clk);
      push_en = 1'b0; pop_en = 1'b0;
      check($sformatf("R4/R5 count v%0d", v), int'(count), int'(VEC[v][15:13]));
      check($sformatf("R5 free v%0d", v), int'(free_regs), int'(VEC[v][12:9]));
      check($sformatf("R2/R3 pop_valid v%0d", v), int'(pop_valid), int'(VEC[v][8]));
      if (VEC[v][8]) check($sformatf("R2 pop_seq v%0d", v), int'(pop_seq), int'(VEC[v][7:0]));
    end

    // R6 blocking and release
    push1(7, 1);
    check("R6 free zero", int'(free_regs), 0);
    check("R6 blocked", int'(rename_blocked), 1);
    give(3);
    check("R6 free after release", int'(free_regs), 3);
    check("R6 unblocked", int'(rename_blocked), 0);
    // R7 add and clamp
    give(3);
    check("R7 add", int'(free_regs), 6);
    give(3);
    check("R7 clamp", int'(free_regs), NP);

    // R8/R9/R10 squash walk
    push1(8, 2);
    push1(9, 1);
    push1(10, 3);
    check("R5 free before squash", int'(free_regs), 2);
    check("R4 count before squash", int'(count), 4);
    squash_req = 1'b1; squash_seq = 8'd8;
    @(negedge clk);
    squash_req = 1'b0;
    check("R8 busy raised", int'(busy), 1);
    pop_en = 1'b1; push_en = 1'b1; push_seq = 8'd11; push_ndest = 2'd0;
    @(negedge clk);
    pop_en = 1'b0; push_en = 1'b0;
    check("R10 pop refused while busy", int'(pop_valid), 0);
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    check("R8 busy fell", int'(busy), 0);
    check("R8 count after squash", int'(count), 2);
    check("R9 refund", int'(free_regs), 6);

    // R8 walk stops on empty; R7 refund clamps
    squash_req = 1'b1; squash_seq = 8'd0;
    @(negedge clk);
    squash_req = 1'b0;
    for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    check("R8 drained", int'(count), 0);
    check("R8 empty flag", int'(empty), 1);
    check("R7 refund clamp", int'(free_regs), NP);

    // R2 order and payload after squash
    push1(20, 3);
    pop_en = 1'b1;
    @(negedge clk);
    pop_en = 1'b0;
    check("R2 pop seq", int'(pop_seq), 20);
    check("R2 pop ndest", int'(pop_ndest), 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule